// File: doc/BRIEF.md
# Pseudo-Random Power-of-Two Weighted Accumulate Stage

This block is one stage of a fixed-weight recurrent datapath. Each cycle it takes two signed Q1.31 samples: a pass-through operand that is added unchanged, and a scaled operand that is multiplied by a pseudo-random weight before the add. The registered result is the pass-through operand plus the scaled operand times the weight, saturated to the Q1.31 range.

Weights are never stored. A 10-bit linear feedback shift register steps on every clock. In each cycle its state is decoded into a sign and a right-shift count, so every weight is plus or minus a power of two between 2^-1 and 2^-6, or zero. The multiply therefore becomes an arithmetic shift and a conditional negate. A start strobe reloads a seed at the beginning of each pass. Because the register also steps in idle cycles, the weight sequence seen by a pass repeats exactly whenever the same seed and the same cycle pattern are applied.

Chained stages share the same seed and timing. This lets a larger engine rebuild a sparse, fixed weight matrix on every pass without any weight memory and without any multiplier.

Top module: `pwr2_shift_add_unit`

## Requirements
- R1: One clock edge after a cycle with `in_valid_i` high, `sum_o` equals `reg_in_i` + W × `wgt_in_i` from that cycle, where W is the weight decoded from the generator state of that cycle.
- R2: The generator state steps on every clock edge, whether or not `in_valid_i` is high, from s to {s[8:0], s[9] XOR s[6]}. This is the x^10 + x^7 + 1 polynomial.
- R3: In a cycle with `start_i` high, the weight is decoded from the seed instead of the running state, and the state continues from the step of that seed. The same seed and the same input pattern therefore give identical outputs on every pass.
- R4: A seed of zero is replaced by the non-zero default 10'h1A7. Reset also loads 10'h1A7, so the state is never all zeros.
- R5: Decoding uses state bit 9 as the sign (1 = negative) and state bits [2:0] as the code. Codes 1 to 6 give a magnitude of 2^-code. Codes 0 and 7 give a zero weight, and then `sum_o` equals `reg_in_i`.
- R6: The scaling is an arithmetic right shift. A negative weighting operand keeps its sign and rounds toward minus infinity before the sign of the weight is applied.
- R7: A sum above 32'h7FFFFFFF gives 32'h7FFFFFFF. A sum below 32'h80000000 gives 32'h80000000.
- R8: `out_valid_o` equals `in_valid_i` delayed by one clock. After a cycle with `in_valid_i` low, `sum_o` keeps its previous value.
- R9: During and right after reset, `out_valid_o` is 0 and `sum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of a pass: use and reload the seed |
| seed_i | input | 10 | Seed for the weight generator (zero selects the default) |
| in_valid_i | input | 1 | Operands valid this cycle |
| reg_in_i | input | 32 | Pass-through operand, signed Q1.31 |
| wgt_in_i | input | 32 | Weighted operand, signed Q1.31 |
| out_valid_o | output | 1 | Result valid |
| sum_o | output | 32 | Saturated registered result, signed Q1.31 |

## Verification
Every result is due exactly one clock edge after its operands. The weight that applies is the generator state of the operand cycle itself, and that state is the seed in a start cycle. The bench drives each cycle's operands on a falling edge. On the next falling edge it compares `sum_o` and `out_valid_o` with the expectation computed for the previous cycle. Its own generator model steps once for every driven cycle, idle cycles included, so weight alignment stays exact through gaps and restarts.

// File: rtl/pwr2_pkg.sv
package pwr2_pkg;
    localparam int LFSR_W = 10;
    localparam int CODE_W = 3;
    localparam int SIGN_BIT = 9;
    localparam int TAP_HI = 9;
    localparam int TAP_LO = 6;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic              neg;
        logic              zero;
        logic [CODE_W-1:0] shamt;
    } weight_t;

    function automatic lfsr_t lfsr_step(lfsr_t s);
        return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    endfunction
endpackage

// File: rtl/pwr2_lfsr.sv
module pwr2_lfsr
    import pwr2_pkg::*;
#(
    parameter lfsr_t DEF_SEED = 10'h1A7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  lfsr_t seed_i,
    output lfsr_t state_o
);
    typedef struct packed {
        lfsr_t st;
    } gen_t;

    gen_t  gen_d, gen_q;
    lfsr_t seed_eff;

    always_comb begin
        seed_eff = (seed_i == '0) ? DEF_SEED : seed_i;
        state_o  = load_i ? seed_eff : gen_q.st;
        gen_d    = gen_q;
        gen_d.st = lfsr_step(state_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q.st <= DEF_SEED;
        else        gen_q    <= gen_d;
    end
endmodule

// File: rtl/pwr2_decode.sv
module pwr2_decode
    import pwr2_pkg::*;
#(
    parameter int SHIFT_MIN = 1,
    parameter int SHIFT_MAX = 6
) (
    input  lfsr_t   state_i,
    output weight_t weight_o
);
    localparam logic [CODE_W-1:0] LO = CODE_W'(SHIFT_MIN);
    localparam logic [CODE_W-1:0] HI = CODE_W'(SHIFT_MAX);

    logic [CODE_W-1:0] code;

    always_comb begin
        code           = state_i[CODE_W-1:0];
        weight_o.neg   = state_i[SIGN_BIT];
        weight_o.zero  = (code < LO) || (code > HI);
        weight_o.shamt = code;
    end
endmodule

// File: rtl/pwr2_shift_add.sv
module pwr2_shift_add
    import pwr2_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit SATURATE = 1'b1
) (
    input  logic [DATA_W-1:0] reg_in_i,
    input  logic [DATA_W-1:0] wgt_in_i,
    input  weight_t           weight_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam int EXT_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] shifted;
    logic signed [EXT_W-1:0]  term;
    logic signed [EXT_W-1:0]  total;

    always_comb begin
        shifted = $signed(wgt_in_i) >>> weight_i.shamt;
        if (weight_i.zero)     term = '0;
        else if (weight_i.neg) term = -$signed({shifted[DATA_W-1], shifted});
        else                   term = $signed({shifted[DATA_W-1], shifted});
        total = $signed({reg_in_i[DATA_W-1], reg_in_i}) + term;
    end

    generate
        if (SATURATE) begin : g_sat
            always_comb begin
                if (total[EXT_W-1] != total[EXT_W-2])
                    sum_o = total[EXT_W-1] ? MAX_NEG : MAX_POS;
                else
                    sum_o = total[DATA_W-1:0];
            end
        end else begin : g_wrap
            always_comb sum_o = total[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pwr2_shift_add_unit.sv
module pwr2_shift_add_unit
    import pwr2_pkg::*;
#(
    parameter int    DATA_W    = 32,
    parameter lfsr_t DEF_SEED  = 10'h1A7,
    parameter int    SHIFT_MIN = 1,
    parameter int    SHIFT_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [9:0]        seed_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] reg_in_i,
    input  logic [DATA_W-1:0] wgt_in_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] sum_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] sum;
    } out_t;

    out_t              out_d, out_q;
    lfsr_t             cur_state;
    weight_t           cur_weight;
    logic [DATA_W-1:0] next_sum;

    pwr2_lfsr #(.DEF_SEED(DEF_SEED)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .seed_i (seed_i),
        .state_o(cur_state)
    );

    pwr2_decode #(.SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX)) u_dec (
        .state_i (cur_state),
        .weight_o(cur_weight)
    );

    pwr2_shift_add #(.DATA_W(DATA_W), .SATURATE(1'b1)) u_alu (
        .reg_in_i(reg_in_i),
        .wgt_in_i(wgt_in_i),
        .weight_i(cur_weight),
        .sum_o   (next_sum)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid_i;
        if (in_valid_i) out_d.sum = next_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid_o = out_q.vld;
    assign sum_o       = out_q.sum;
endmodule

// File: rtl/pwr2_unit_chk.sv
module pwr2_unit_chk
    import pwr2_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              in_valid_i,
    input logic [DATA_W-1:0] reg_in_i,
    input logic [DATA_W-1:0] wgt_in_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] sum_o,
    input lfsr_t             cur_state
);
    localparam int W2 = DATA_W + 2;

    logic              prev_vld;
    logic [DATA_W-1:0] prev_reg, prev_wgt;
    logic signed [W2-1:0] dev, dev_abs, lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld <= 1'b0;
            prev_reg <= '0;
            prev_wgt <= '0;
        end else begin
            prev_vld <= in_valid_i;
            prev_reg <= reg_in_i;
            prev_wgt <= wgt_in_i;
        end
    end

    always_comb begin
        dev     = W2'($signed(sum_o)) - W2'($signed(prev_reg));
        dev_abs = dev[W2-1] ? -dev : dev;
        lim     = W2'($signed(prev_wgt));
        lim     = lim[W2-1] ? -lim : lim;
        lim     = (lim >>> 1) + W2'(1);
    end

    // R8: valid tracks the input valid one edge later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid_o == $past(in_valid_i)));

    // R8: idle cycle holds the result
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(sum_o));

    // R4: generator never reaches the all-zero lockup state
    a_r4_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state != '0);

    // R2: outside a start cycle the state is one step on from the last cycle
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (start_i || cur_state == lfsr_step($past(cur_state))));

    // R5: codes 0 and 7 pass the regular operand through unchanged
    a_r5_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (cur_state[2:0] == 3'd0 || cur_state[2:0] == 3'd7))
        |=> (sum_o == $past(reg_in_i)));

    // R1: the weighted term never exceeds half the weighted operand
    a_r1_bounded_term: assert property (@(posedge clk) disable iff (!rst_n)
        prev_vld |-> (dev_abs <= lim));
endmodule

bind pwr2_shift_add_unit pwr2_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .reg_in_i   (reg_in_i),
    .wgt_in_i   (wgt_in_i),
    .out_valid_o(out_valid_o),
    .sum_o      (sum_o),
    .cur_state  (cur_state)
);

// File: tb/sim_pwr2_shift_add_unit.sv
`timescale 1ns/1ps
module sim_pwr2_shift_add_unit;
    localparam logic [9:0] DEF = 10'h1A7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  seed_i = '0;
    logic        in_valid_i = 1'b0;
    logic [31:0] reg_in_i = '0;
    logic [31:0] wgt_in_i = '0;
    logic        out_valid_o;
    logic [31:0] sum_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [9:0]  m_state;
    logic [31:0] exp_sum = '0;
    logic        exp_vld = 1'b0;
    bit          pend = 1'b0;
    string       pend_tag = "R1";
    logic [31:0] last_obs;
    logic [31:0] pass_a [16];

    always #4 clk = ~clk;

    pwr2_shift_add_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .in_valid_i(in_valid_i), .reg_in_i(reg_in_i), .wgt_in_i(wgt_in_i),
        .out_valid_o(out_valid_o), .sum_o(sum_o)
    );

    function automatic logic [9:0] model_step(logic [9:0] s);
        return {s[8:0], s[9] ^ s[6]};
    endfunction

    function automatic logic [31:0] model_sum(logic [9:0] st, logic [31:0] r, logic [31:0] w);
        logic signed [31:0] sh;
        logic signed [32:0] t, s;
        int code;
        code = int'(st[2:0]);
        t = '0;
        if (code >= 1 && code <= 6) begin
            sh = $signed(w) >>> code;
            t = st[9] ? -$signed({sh[31], sh}) : $signed({sh[31], sh});
        end
        s = $signed({r[31], r}) + t;
        if (s[32] != s[31]) return s[32] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return s[31:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: checks last cycle's result, drives this cycle.
    task automatic cyc(string tag, bit vld, bit st, logic [9:0] sd,
                       logic [31:0] r, logic [31:0] w);
        logic [9:0] used;
        if (pend) begin
            check({pend_tag, " valid"}, {31'b0, out_valid_o}, {31'b0, exp_vld});
            check(pend_tag, sum_o, exp_sum);
        end
        last_obs = sum_o;
        start_i = st; seed_i = sd; in_valid_i = vld; reg_in_i = r; wgt_in_i = w;
        used = st ? ((sd == '0) ? DEF : sd) : m_state;
        exp_vld = vld;
        if (vld) exp_sum = model_sum(used, r, w);
        m_state = model_step(used);
        pend = 1'b1;
        pend_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        cyc(tag, 1'b0, 1'b0, '0, 32'h1234_5678, 32'h7654_3210);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'b0, out_valid_o}, 32'd0);
        check("R9 reset sum", sum_o, 32'd0);
        rst_n = 1'b1;
        m_state = DEF;
        pend = 1'b0;
        exp_sum = '0;
    endtask

    task automatic t_default_after_reset;
        // R4: no start after reset, default state drives the weights
        for (int i = 0; i < 6; i++)
            cyc("R4 reset default", 1'b1, 1'b0, '0, 32'h0100_0000 * i, 32'h4000_0000 - 32'h0300_0000 * i);
        idle("R4 reset default");
    endtask

    task automatic t_stream;
        // R1/R2/R6: random operands, state keeps stepping
        cyc("R1 stream", 1'b1, 1'b1, 10'h2C5, $urandom, $urandom);
        for (int i = 0; i < 40; i++)
            cyc("R1 stream", 1'b1, 1'b0, '0, $urandom, $urandom);
        idle("R1 stream");
    endtask

    task automatic t_idle_gap;
        // R2/R8: weights keep stepping while idle, result held
        cyc("R2 gap", 1'b1, 1'b1, 10'h0F3, 32'h1111_0000, 32'hC000_0000);
        for (int i = 0; i < 5; i++) idle("R8 hold");
        for (int i = 0; i < 8; i++)
            cyc("R2 gap resume", 1'b1, 1'b0, '0, 32'hF000_0000 + i, 32'h6000_0000 - i);
        idle("R8 hold");
    endtask

    task automatic t_repeat;
        // R3: two passes from the same seed give identical outputs
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 16; i++) begin
                cyc("R3 repeat", 1'b1, i == 0, 10'h3B1, 32'h0500_0000 * i, 32'h9000_0000 + 32'h0700_0000 * i);
                if (i > 0) begin
                    if (pass == 0) pass_a[i-1] = last_obs;
                    else check("R3 repeat pass compare", last_obs, pass_a[i-1]);
                end
            end
            idle("R3 repeat");
            if (pass == 0) pass_a[15] = last_obs;
            else check("R3 repeat pass compare", last_obs, pass_a[15]);
            idle("R3 repeat");
        end
    endtask

    task automatic t_zero_seed;
        // R4: zero seed behaves as the default seed
        cyc("R4 zero seed", 1'b1, 1'b1, 10'h000, 32'h0000_0100, 32'h7000_0000);
        for (int i = 0; i < 5; i++)
            cyc("R4 zero seed", 1'b1, 1'b0, '0, 32'h0000_0100, 32'h7000_0000);
        idle("R4 zero seed");
    endtask

    task automatic t_codes;
        // R5: code 0 and code 7 pass the regular operand unchanged
        cyc("R5 code0", 1'b1, 1'b1, 10'h200, 32'h1357_9BDF, 32'h7FFF_FFFF);
        idle("R5 code0");
        check("R5 code0 literal", last_obs, 32'h1357_9BDF);
        cyc("R5 code7", 1'b1, 1'b1, 10'h007, 32'hDEAD_0000, 32'h8000_0000);
        idle("R5 code7");
        check("R5 code7 literal", last_obs, 32'hDEAD_0000);
        // R5: code 1 halves, code 6 divides by 64
        cyc("R5 code1", 1'b1, 1'b1, 10'h001, 32'h0000_0000, 32'h4000_0000);
        idle("R5 code1");
        check("R5 code1 literal", last_obs, 32'h2000_0000);
        cyc("R5 code6 neg", 1'b1, 1'b1, 10'h206, 32'h0000_0000, 32'h4000_0000);
        idle("R5 code6 neg");
        check("R5 code6 literal", last_obs, 32'hFF00_0000);
        // R6: arithmetic shift of a negative operand, rounding down
        cyc("R6 arith", 1'b1, 1'b1, 10'h002, 32'h0000_0000, 32'hFFFF_FFFB);
        idle("R6 arith");
        check("R6 arith literal", last_obs, 32'hFFFF_FFFE);
        cyc("R6 arith neg", 1'b1, 1'b1, 10'h206, 32'h0000_0000, 32'h8000_0000);
        idle("R6 arith neg");
        check("R6 arith neg literal", last_obs, 32'h0200_0000);
    endtask

    task automatic t_saturate;
        // R7: positive and negative clamp
        cyc("R7 sat pos", 1'b1, 1'b1, 10'h001, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        idle("R7 sat pos");
        check("R7 sat pos literal", last_obs, 32'h7FFF_FFFF);
        cyc("R7 sat neg", 1'b1, 1'b1, 10'h201, 32'h8000_0000, 32'h7FFF_FFFF);
        idle("R7 sat neg");
        check("R7 sat neg literal", last_obs, 32'h8000_0000);
        cyc("R7 no sat edge", 1'b1, 1'b1, 10'h001, 32'h6000_0000, 32'h3FFF_FFFE);
        idle("R7 no sat edge");
        check("R7 no sat literal", last_obs, 32'h7FFF_FFFF);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_default_after_reset();
        t_stream();
        t_idle_gap();
        t_repeat();
        t_zero_seed();
        t_codes();
        t_saturate();
        t_reset();
        idle("R9 after reset");
        idle("R9 after reset");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule